// File: doc/BRIEF.md
# Secondary Processor Startup Sequencer

This block brings one secondary processor out of reset without software stepping through the timing. A single start pulse hands it a target processor ID and a page index for the startup code. It then drives a 32-bit register-write master port connected to an interrupt command register pair. It sends an init message and waits. It sends a startup message, waits a short time and looks at an alive flag raised by the secondary processor. If the flag is still low, it sends the startup message once more, waits much longer and looks again.

Every delay is counted in pulses of a once-per-millisecond tick input, so the block has no notion of the clock frequency. Before each command it waits for the command block's delivery status to read idle. Each command is two writes: a high word that carries the target ID, then a low word that carries the delivery mode and payload. The run ends with either a done flag or a fail flag. The flag is held, together with the ID it refers to, until the next accepted start.

Top module: `ap_boot_seq`

## Requirements
- R1: A start pulse is taken only while `busy_o` is low. A start pulse during a run is ignored, and the run keeps using the ID and page captured at its start.
- R2: Every command is a high-word write (`wr_hi_o`=1) with the target ID in bits [31:24] and all other bits zero. It is followed in the very next cycle by a low-word write (`wr_hi_o`=0).
- R3: The first command of a run is an init message with low word 0x00000500 (delivery mode 3'b101 in bits [10:8]).
- R4: Between the low-word write of the init message and the high-word write of the next command, exactly `INIT_WAIT_MS` tick pulses are counted.
- R5: A startup message has low word 0x00000600 OR'd with the page index in bits [7:0] (delivery mode 3'b110).
- R6: After the first startup message the block counts `FIRST_WAIT_MS` ticks and then samples `alive_i`. If the flag is high, it sets `done_o` and issues no further writes.
- R7: If `alive_i` is low at that sample, a second startup message is sent, followed by exactly `RETRY_WAIT_MS` ticks before `alive_i` is sampled again. If the flag is high at that second sample, the block sets `done_o`.
- R8: If `alive_i` is still low at the second sample, the block sets `fail_o`. `done_o` and `fail_o` are never high together.
- R9: No high-word write is issued while `dlv_busy_i` is high. The block holds the pending command until the status reads idle.
- R10: `done_o`, `fail_o` and `result_id_o` hold their values until the next accepted start. That start clears `done_o` and `fail_o` and loads the new ID.
- R11: After reset, `busy_o`, `done_o`, `fail_o` and `wr_en_o` are low, and no write occurs until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| target_id_i | input | ID_W | ID of the processor to bring up |
| page_i | input | PAGE_W | Page index of the startup code |
| ms_tick_i | input | 1 | One pulse per millisecond |
| alive_i | input | 1 | Alive flag raised by the secondary processor |
| dlv_busy_i | input | 1 | Delivery status of the command block, high while sending |
| wr_en_o | output | 1 | Register write strobe |
| wr_hi_o | output | 1 | 1 selects the high command word, 0 the low word |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run succeeded (held) |
| fail_o | output | 1 | Last run gave up on its target (held) |
| result_id_o | output | ID_W | ID of the target the held result refers to |

## Verification
The bench builds the block with `INIT_WAIT_MS`=10 and `FIRST_WAIT_MS`=1, the same as the defaults, but shortens `RETRY_WAIT_MS` to 40. The two first waits are therefore checked at their real tick counts, while a run that ends in failure still takes only a few hundred cycles. With the tick spaced five clocks apart, the exact number of ticks in each gap between commands can be compared. The runs cover success on the first look, success on the retry, failure, a stalled delivery status and a start pulse sent mid-run.

// File: rtl/ap_boot_pkg.sv
package ap_boot_pkg;

  localparam logic [2:0] DM_INIT  = 3'b101;
  localparam logic [2:0] DM_START = 3'b110;

  typedef enum logic [0:0] {
    CMD_INIT  = 1'b0,
    CMD_START = 1'b1
  } cmd_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_INIT_CMD,
    SQ_INIT_WAIT,
    SQ_START1_CMD,
    SQ_START1_WAIT,
    SQ_START2_CMD,
    SQ_START2_WAIT
  } seq_st_e;

  typedef enum logic [1:0] {
    IS_IDLE,
    IS_HI,
    IS_LO
  } iss_st_e;

  function automatic logic [31:0] lo_word(cmd_kind_e kind, logic [7:0] page);
    logic [31:0] w;
    w = 32'h0;
    if (kind == CMD_INIT) begin
      w[10:8] = DM_INIT;
    end else begin
      w[10:8] = DM_START;
      w[7:0]  = page;
    end
    return w;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ap_ms_delay.sv
module ap_ms_delay #(
  parameter int unsigned MAX_MS = 1000,
  localparam int unsigned CW = $clog2(MAX_MS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          tick_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load_i) begin
      cnt_d = len_i;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        act_d = 1'b0;
      end else if (tick_i) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign expired_o = act_q && (cnt_q == '0);

  assert_single_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o && !load_i |=> !expired_o);

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !load_i |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/ap_cmd_issuer.sv
module ap_cmd_issuer
  import ap_boot_pkg::*;
#(
  parameter int unsigned ID_W   = 8,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  cmd_kind_e         kind_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              dlv_busy_i,
  output logic              wr_en_o,
  output logic              wr_hi_o,
  output logic [31:0]       wr_data_o,
  output logic              done_o
);

  iss_st_e st_q, st_d;
  logic [7:0] id8;
  logic [7:0] page8;

  assign id8   = 8'(id_i);
  assign page8 = 8'(page_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      IS_IDLE: if (req_i && !dlv_busy_i) st_d = IS_HI;
      IS_HI:   st_d = IS_LO;
      IS_LO:   st_d = IS_IDLE;
      default: st_d = IS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= IS_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_hi_o   = 1'b0;
    wr_data_o = 32'h0;
    done_o    = 1'b0;
    unique case (st_q)
      IS_HI: begin
        wr_en_o   = 1'b1;
        wr_hi_o   = 1'b1;
        wr_data_o = {id8, 24'h0};
      end
      IS_LO: begin
        wr_en_o   = 1'b1;
        wr_data_o = lo_word(kind_i, page8);
        done_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assert_lo_follows_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && !wr_hi_o |-> $past(wr_en_o && wr_hi_o));

  assert_hi_then_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && wr_hi_o |=> wr_en_o && !wr_hi_o);

  assert_launch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && wr_hi_o |-> $past(!dlv_busy_i && req_i));

endmodule

// File: rtl/ap_boot_seq.sv
module ap_boot_seq
  import ap_boot_pkg::*;
#(
  parameter int unsigned ID_W          = 8,
  parameter int unsigned PAGE_W        = 8,
  parameter int unsigned INIT_WAIT_MS  = 10,
  parameter int unsigned FIRST_WAIT_MS = 1,
  parameter int unsigned RETRY_WAIT_MS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ID_W-1:0]   target_id_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              ms_tick_i,
  input  logic              alive_i,
  input  logic              dlv_busy_i,
  output logic              wr_en_o,
  output logic              wr_hi_o,
  output logic [31:0]       wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ID_W-1:0]   result_id_o
);

  localparam int unsigned MAX_MS = max3(INIT_WAIT_MS, FIRST_WAIT_MS, RETRY_WAIT_MS);
  localparam int unsigned CW     = $clog2(MAX_MS + 1);

  seq_st_e           st_q, st_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;

  logic              cmd_req;
  cmd_kind_e         cmd_kind;
  logic              cmd_done;
  logic              dly_load;
  logic [CW-1:0]     dly_len;
  logic              dly_exp;
  logic              accept;

  assign accept = start_i && (st_q == SQ_IDLE);

  always_comb begin
    st_d     = st_q;
    id_d     = id_q;
    page_d   = page_q;
    done_d   = done_q;
    fail_d   = fail_q;
    cmd_req  = 1'b0;
    cmd_kind = CMD_START;
    dly_load = 1'b0;
    dly_len  = '0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          id_d   = target_id_i;
          page_d = page_i;
          done_d = 1'b0;
          fail_d = 1'b0;
          st_d   = SQ_INIT_CMD;
        end
      end
      SQ_INIT_CMD: begin
        cmd_req  = 1'b1;
        cmd_kind = CMD_INIT;
        if (cmd_done) begin
          dly_load = 1'b1;
          dly_len  = CW'(INIT_WAIT_MS);
          st_d     = SQ_INIT_WAIT;
        end
      end
      SQ_INIT_WAIT: begin
        if (dly_exp) st_d = SQ_START1_CMD;
      end
      SQ_START1_CMD: begin
        cmd_req = 1'b1;
        if (cmd_done) begin
          dly_load = 1'b1;
          dly_len  = CW'(FIRST_WAIT_MS);
          st_d     = SQ_START1_WAIT;
        end
      end
      SQ_START1_WAIT: begin
        if (dly_exp) begin
          if (alive_i) begin
            done_d = 1'b1;
            st_d   = SQ_IDLE;
          end else begin
            st_d = SQ_START2_CMD;
          end
        end
      end
      SQ_START2_CMD: begin
        cmd_req = 1'b1;
        if (cmd_done) begin
          dly_load = 1'b1;
          dly_len  = CW'(RETRY_WAIT_MS);
          st_d     = SQ_START2_WAIT;
        end
      end
      SQ_START2_WAIT: begin
        if (dly_exp) begin
          if (alive_i) done_d = 1'b1;
          else         fail_d = 1'b1;
          st_d = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      id_q   <= '0;
      page_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      id_q   <= id_d;
      page_q <= page_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  ap_cmd_issuer #(
    .ID_W   (ID_W),
    .PAGE_W (PAGE_W)
  ) u_issuer (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (cmd_req),
    .kind_i     (cmd_kind),
    .id_i       (id_q),
    .page_i     (page_q),
    .dlv_busy_i (dlv_busy_i),
    .wr_en_o    (wr_en_o),
    .wr_hi_o    (wr_hi_o),
    .wr_data_o  (wr_data_o),
    .done_o     (cmd_done)
  );

  ap_ms_delay #(
    .MAX_MS (MAX_MS)
  ) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (dly_load),
    .len_i     (dly_len),
    .tick_i    (ms_tick_i),
    .expired_o (dly_exp)
  );

  assign busy_o      = (st_q != SQ_IDLE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign result_id_o = id_q;

  assert_id_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(result_id_o) || !$past(busy_o) || $fell(busy_o) || !busy_o);

  assert_busy_holds_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(result_id_o));

  assert_excl_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) && !accept |=> $stable(done_o) && $stable(fail_o) && $stable(result_id_o));

  assert_no_write_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !wr_en_o);

  assert_flags_clear_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o && !fail_o);

endmodule

// File: tb/ap_boot_seq_tb.sv
module ap_boot_seq_tb;

  localparam int unsigned ID_W   = 8;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned W_INIT  = 10;
  localparam int unsigned W_FIRST = 1;
  localparam int unsigned W_RETRY = 40;
  localparam int unsigned TICK_P  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [ID_W-1:0]   target_id_i;
  logic [PAGE_W-1:0] page_i;
  logic              ms_tick_i;
  logic              alive_i;
  logic              dlv_busy_i;
  logic              wr_en_o;
  logic              wr_hi_o;
  logic [31:0]       wr_data_o;
  logic              busy_o;
  logic              done_o;
  logic              fail_o;
  logic [ID_W-1:0]   result_id_o;

  ap_boot_seq #(
    .ID_W          (ID_W),
    .PAGE_W        (PAGE_W),
    .INIT_WAIT_MS  (W_INIT),
    .FIRST_WAIT_MS (W_FIRST),
    .RETRY_WAIT_MS (W_RETRY)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .target_id_i (target_id_i),
    .page_i      (page_i),
    .ms_tick_i   (ms_tick_i),
    .alive_i     (alive_i),
    .dlv_busy_i  (dlv_busy_i),
    .wr_en_o     (wr_en_o),
    .wr_hi_o     (wr_hi_o),
    .wr_data_o   (wr_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .result_id_o (result_id_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int wr_count = 0;
  int alive_mode = 0;
  int start_seen = 0;
  int tick_cnt = 0;
  int tick_phase = 0;
  bit after_lo = 1'b0;
  bit finished = 1'b0;

  logic [32:0] exp_q[$];
  int          wait_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // tick generator, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      tick_phase <= 0;
      ms_tick_i  <= 1'b0;
    end else begin
      tick_phase <= (tick_phase == TICK_P - 1) ? 0 : tick_phase + 1;
      ms_tick_i  <= (tick_phase == TICK_P - 1);
    end
  end

  // monitor: pops expected writes and wait lengths, raises the alive flag
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en_o) begin
        logic [32:0] e;
        wr_count++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected write", {wr_hi_o, wr_data_o}, 0);
        end else begin
          e = exp_q.pop_front();
          check({wr_hi_o, wr_data_o} == e, "R2/R3/R5", "write word",
                {wr_hi_o, wr_data_o}, e);
        end
        if (wr_hi_o && after_lo) begin
          int w;
          w = (wait_q.size() != 0) ? wait_q.pop_front() : -1;
          check(tick_cnt == w, "R4/R7", "ticks between commands", tick_cnt, w);
        end
        if (!wr_hi_o) begin
          after_lo = 1'b1;
          tick_cnt = 0;
          if (wr_data_o[10:8] == 3'b110) begin
            start_seen++;
            if (start_seen == alive_mode) alive_i <= 1'b1;
          end
        end
      end else if (ms_tick_i) begin
        tick_cnt++;
      end
    end
  end

  task automatic push_cmd(input logic [7:0] id, input logic [31:0] lo);
    exp_q.push_back({1'b1, id, 24'h0});
    exp_q.push_back({1'b0, lo});
  endtask

  // driver: pushes the expected items for one run and starts it
  task automatic run(input logic [7:0] id, input logic [7:0] page, input int mode);
    logic [31:0] sw;
    sw = 32'h600 | {24'h0, page};
    push_cmd(id, 32'h500);
    wait_q.push_back(W_INIT);
    push_cmd(id, sw);
    if (mode != 1) begin
      wait_q.push_back(W_FIRST);
      push_cmd(id, sw);
    end
    alive_mode = mode;
    start_seen = 0;
    after_lo   = 1'b0;
    alive_i    = 1'b0;
    target_id_i = id;
    page_i      = page;
    start_i     = 1'b1;
    @(negedge clk);
    start_i     = 1'b0;
    check(busy_o === 1'b1 && done_o === 1'b0 && fail_o === 1'b0, "R10",
          "flags cleared on start", {busy_o, done_o, fail_o}, 3'b100);
  endtask

  task automatic finish_run(input logic [7:0] id, input bit exp_done);
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done_o == exp_done, exp_done ? "R6/R7" : "R8", "done", done_o, exp_done);
    check(fail_o == !exp_done, "R8", "fail", fail_o, !exp_done);
    check(result_id_o == id, "R10", "result id", result_id_o, id);
    check(exp_q.size() == 0, "R6", "writes left", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    target_id_i = '0;
    page_i = '0;
    alive_i = 1'b0;
    dlv_busy_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy_o && !done_o && !fail_o && !wr_en_o && wr_count == 0, "R11",
          "reset state", {busy_o, done_o, fail_o, wr_en_o}, 0);

    // R6 success on the first look
    run(8'h05, 8'h08, 1);
    finish_run(8'h05, 1'b1);

    // R10 result held while idle
    repeat (50) @(negedge clk);
    check(done_o && !fail_o && result_id_o == 8'h05, "R10", "held result",
          {done_o, fail_o, result_id_o}, {2'b10, 8'h05});

    // R7 success on the retry
    run(8'hA3, 8'h9C, 2);
    finish_run(8'hA3, 1'b1);

    // R8 failure after retry
    run(8'h7E, 8'hFF, 0);
    finish_run(8'h7E, 1'b0);

    // R9 delivery status stalls the first command
    dlv_busy_i = 1'b1;
    run(8'h11, 8'h01, 1);
    repeat (30) @(negedge clk);
    check(!wr_en_o && exp_q.size() == 4, "R9", "no write while delivering",
          exp_q.size(), 4);
    dlv_busy_i = 1'b0;
    // R1 start mid-run ignored: expected words still carry 0x11
    repeat (10) @(negedge clk);
    target_id_i = 8'h99;
    page_i      = 8'h44;
    start_i     = 1'b1;
    @(negedge clk);
    start_i     = 1'b0;
    check(result_id_o == 8'h11, "R1", "id after ignored start", result_id_o, 8'h11);
    finish_run(8'h11, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule